// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder Model

This block is a clocked behavioural model of the control logic inside an asynchronous, multiplexed-address DRAM with 4-bit data and extended-data-out reads. A fast sample clock oversamples the active-low row strobe, column strobe, write enable and output enable together with the address and data-in pins. At every row-strobe falling edge the model decides what kind of cycle begins from the other strobe levels: a normal access (which doubles as a row-only refresh when no column strobe follows), a column-before-row refresh driven by an internal row counter, or a write-and-column-before-row cycle that switches on a compressed test mode.

Storage is a small array whose row and column widths are parameters, so a controller testbench can simulate it quickly. Reads hold their data after the column strobe rises and release it under the extended-data-out rules. The model watches the controller and raises sticky flags when an access comes before the power-up sequence is complete, or when any row goes too long without a refresh.

Top module: `dram_edo_model`

## Requirements
- R1: While and after reset, `dq_drive`, `init_err` and `ret_err` are 0.
- R2: A column-strobe falling edge in an access cycle with write enable high and output enable low drives the addressed word on `dq_out` with `dq_drive` 1 from the next sample on; the data stays driven after the column strobe rises, and each further column-strobe fall within the same row cycle drives the newly addressed word.
- R3: Write enable low at a column-strobe fall in an access cycle stores `dq_in` at the addressed word, and `dq_drive` stays 0 for that cycle.
- R4: Driven data is released (`dq_drive` 0) on an output-enable rise, on a write-enable fall while the column strobe is high, and once both strobes are high after either rises; output enable falling again does not bring the data back before the next column access.
- R5: A write-enable fall while a read's column strobe is still low keeps the old word on `dq_out` and stores `dq_in` at the read's address.
- R6: With the column strobe high at the row-strobe fall, the address pins give the row for the access and that row counts as refreshed.
- R7: Column strobe low and write enable high at the row-strobe fall is a counter refresh: the row counter's value is refreshed, the counter then advances modulo 2^ROW_W, and test mode ends.
- R8: Column strobe and write enable both low at the row-strobe fall enters test mode, refreshes the counter row and advances the counter; repeating it keeps test mode.
- R9: In test mode each read returns the bitwise XOR of the two words whose column addresses differ only in bit 0 (0 where they agree, 1 where they differ), and each write stores `dq_in` into both words.
- R10: A row cycle with no column-strobe fall ends test mode.
- R11: `init_err` goes to 1 and stays there if a column access occurs before PAUSE_CYC samples after reset followed by INIT_CNT refresh cycles (row-only or counter refresh); eight such cycles after the pause are enough, seven are not.
- R12: `ret_err` goes to 1 and stays there when any row goes RET_LIMIT samples without a refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock that oversamples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Data presented by the controller |
| dq_out | output | DQ_W | Data returned by the model |
| dq_drive | output | 1 | 1 while the model drives `dq_out` |
| init_err | output | 1 | Sticky flag: access before power-up sequence |
| ret_err | output | 1 | Sticky flag: a row missed its refresh window |

## Verification
Every strobe edge is seen through a single sampling register, so each output effect (data driven, data released, test mode switched, a word stored) becomes visible at the first sample edge after the strobe changes. The bench changes inputs on the falling clock edge and reads outputs on the next falling edge, exactly one rising edge later, so every check lands in the cycle the result is due. Stored words are checked by reading them back later through normal cycles, and the refresh counter is checked through the retention flag, which stays clear only if counter refreshes alone cover every row.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;

  typedef enum logic [1:0] {
    CYC_NONE,
    CYC_ACCESS,
    CYC_CBR,
    CYC_WCBR
  } cyc_e;

  localparam int SIG_RAS = 0;
  localparam int SIG_CAS = 1;
  localparam int SIG_WE  = 2;
  localparam int SIG_OE  = 3;
  localparam int NSIG    = 4;

endpackage

// File: rtl/dram_edge_det.sv
module dram_edge_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  assign prev = prev_q;

endmodule

// File: rtl/dram_init_mon.sv
module dram_init_mon #(
  parameter int PAUSE_CYC = 16,
  parameter int INIT_CNT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_evt,
  input  logic access_evt,
  output logic init_err
);

  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int CW = $clog2(INIT_CNT + 1);

  logic [PW-1:0] pause_q, pause_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          pause_done, ready;

  assign pause_done = (pause_q == PW'(PAUSE_CYC));
  assign ready      = pause_done && (cnt_q == CW'(INIT_CNT));

  always_comb begin
    pause_d = pause_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    if (!pause_done) pause_d = pause_q + PW'(1);
    if (pause_done && init_evt && !ready) cnt_d = cnt_q + CW'(1);
    if (access_evt && !ready) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      pause_q <= pause_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  assign init_err = err_q;

endmodule

// File: rtl/dram_ret_mon.sv
module dram_ret_mon #(
  parameter int ROW_W     = 4,
  parameter int RET_LIMIT = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refr_evt,
  input  logic [ROW_W-1:0] refr_row,
  output logic             ret_err
);

  localparam int ROWS = 1 << ROW_W;
  localparam int TW   = $clog2(RET_LIMIT + 1);

  logic [ROWS-1:0] expired;
  logic            err_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [TW-1:0] tmr_q, tmr_d;
    logic          hit;
    assign hit        = refr_evt && (refr_row == ROW_W'(r));
    assign expired[r] = (tmr_q == TW'(RET_LIMIT));
    always_comb begin
      tmr_d = tmr_q;
      if (hit)           tmr_d = '0;
      else if (!expired[r]) tmr_d = tmr_q + TW'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_q <= '0;
      else        tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (|expired) err_q <= 1'b1;
  end

  assign ret_err = err_q;

endmodule

// File: rtl/dram_store.sv
module dram_store #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int DQ_W  = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_pair,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [DQ_W-1:0]  rd_data,
  output logic [DQ_W-1:0]  rd_mate
);

  localparam int DEPTH = 1 << (ROW_W + COL_W);

  logic [DQ_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_pair) begin
        mem[{wr_row, wr_col[COL_W-1:1], 1'b0}] <= wr_data;
        mem[{wr_row, wr_col[COL_W-1:1], 1'b1}] <= wr_data;
      end else begin
        mem[{wr_row, wr_col}] <= wr_data;
      end
    end
  end

  assign rd_data = mem[{rd_row, rd_col}];
  assign rd_mate = mem[{rd_row, rd_col[COL_W-1:1], ~rd_col[0]}];

endmodule

// File: rtl/dram_edo_model.sv
module dram_edo_model
  import dram_model_pkg::*;
#(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 4,
  parameter int DQ_W      = 4,
  parameter int PAUSE_CYC = 16,
  parameter int INIT_CNT  = 8,
  parameter int RET_LIMIT = 3000,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_drive,
  output logic              init_err,
  output logic              ret_err
);

  logic [NSIG-1:0] lvl, prev;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, oe_rise;

  assign lvl = {oe_n, we_n, cas_n, ras_n};

  dram_edge_det #(.W(NSIG)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .prev(prev)
  );

  assign ras_fall = prev[SIG_RAS] & ~ras_n;
  assign ras_rise = ~prev[SIG_RAS] & ras_n;
  assign cas_fall = prev[SIG_CAS] & ~cas_n;
  assign cas_rise = ~prev[SIG_CAS] & cas_n;
  assign we_fall  = prev[SIG_WE] & ~we_n;
  assign oe_rise  = ~prev[SIG_OE] & oe_n;

  cyc_e             cyc_q, cyc_d;
  logic [ROW_W-1:0] row_q, row_d, rcnt_q, rcnt_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             cas_seen_q, cas_seen_d;
  logic             rd_open_q, rd_open_d;
  logic             tm_q, tm_d;
  logic             drive_q, drive_d;
  logic [DQ_W-1:0]  dout_q, dout_d;

  logic [ROW_W-1:0] row_in;
  logic [COL_W-1:0] col_in;
  logic acc_cas, early_wr, rd_strobe, rmw_wr, ras_only_end;
  logic init_evt, refr_evt;
  logic [ROW_W-1:0] refr_row;
  logic [DQ_W-1:0]  rd_data, rd_mate, rd_word;

  assign row_in       = addr[ROW_W-1:0];
  assign col_in       = addr[COL_W-1:0];
  assign acc_cas      = cas_fall && (cyc_q == CYC_ACCESS) && !ras_n;
  assign early_wr     = acc_cas && !we_n;
  assign rd_strobe    = acc_cas && we_n;
  assign rmw_wr       = rd_open_q && we_fall && !cas_n && !ras_n;
  assign ras_only_end = ras_rise && (cyc_q == CYC_ACCESS) && !cas_seen_q;
  assign init_evt     = (ras_fall && !cas_n && we_n) || ras_only_end;
  assign refr_evt     = ras_fall;
  assign refr_row     = cas_n ? row_in : rcnt_q;

  dram_store #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_store (
    .clk(clk),
    .wr_en(early_wr || rmw_wr),
    .wr_pair(tm_q),
    .wr_row(row_q),
    .wr_col(early_wr ? col_in : col_q),
    .wr_data(dq_in),
    .rd_row(row_q),
    .rd_col(col_in),
    .rd_data(rd_data),
    .rd_mate(rd_mate)
  );

  assign rd_word = tm_q ? (rd_data ^ rd_mate) : rd_data;

  always_comb begin
    cyc_d      = cyc_q;
    row_d      = row_q;
    rcnt_d     = rcnt_q;
    col_d      = col_q;
    cas_seen_d = cas_seen_q;
    rd_open_d  = rd_open_q;
    tm_d       = tm_q;
    drive_d    = drive_q;
    dout_d     = dout_q;

    if (ras_fall) begin
      cas_seen_d = 1'b0;
      if (cas_n) begin
        cyc_d = CYC_ACCESS;
        row_d = row_in;
      end else begin
        cyc_d  = we_n ? CYC_CBR : CYC_WCBR;
        row_d  = rcnt_q;
        rcnt_d = rcnt_q + ROW_W'(1);
        tm_d   = !we_n;
      end
    end
    if (ras_rise) begin
      cyc_d = CYC_NONE;
      if (ras_only_end) tm_d = 1'b0;
    end

    if (acc_cas) begin
      cas_seen_d = 1'b1;
      col_d      = col_in;
    end
    if (rd_strobe) begin
      rd_open_d = 1'b1;
      dout_d    = rd_word;
      drive_d   = !oe_n;
    end
    if (cas_rise || ras_rise || rmw_wr) rd_open_d = 1'b0;

    if (early_wr) drive_d = 1'b0;
    if (oe_rise) drive_d = 1'b0;
    if (we_fall && cas_n) drive_d = 1'b0;
    if ((ras_rise || cas_rise) && ras_n && cas_n) drive_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q      <= CYC_NONE;
      row_q      <= '0;
      rcnt_q     <= '0;
      col_q      <= '0;
      cas_seen_q <= 1'b0;
      rd_open_q  <= 1'b0;
      tm_q       <= 1'b0;
      drive_q    <= 1'b0;
      dout_q     <= '0;
    end else begin
      cyc_q      <= cyc_d;
      row_q      <= row_d;
      rcnt_q     <= rcnt_d;
      col_q      <= col_d;
      cas_seen_q <= cas_seen_d;
      rd_open_q  <= rd_open_d;
      tm_q       <= tm_d;
      drive_q    <= drive_d;
      dout_q     <= dout_d;
    end
  end

  dram_init_mon #(.PAUSE_CYC(PAUSE_CYC), .INIT_CNT(INIT_CNT)) u_init (
    .clk(clk), .rst_n(rst_n), .init_evt(init_evt),
    .access_evt(acc_cas), .init_err(init_err)
  );

  dram_ret_mon #(.ROW_W(ROW_W), .RET_LIMIT(RET_LIMIT)) u_ret (
    .clk(clk), .rst_n(rst_n), .refr_evt(refr_evt),
    .refr_row(refr_row), .ret_err(ret_err)
  );

  assign dq_out   = dout_q;
  assign dq_drive = drive_q;

endmodule

// File: rtl/dram_edo_chk.sv
module dram_edo_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic ras_fall,
  input logic ras_rise,
  input logic cas_fall,
  input logic cas_rise,
  input logic oe_rise,
  input logic tm_q,
  input logic dq_drive,
  input logic init_err,
  input logic ret_err
);

  // R2
  drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_drive) |-> $past(cas_fall) && $past(we_n));

  // R3
  early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !ras_n && !we_n) |=> !dq_drive);

  // R4
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_rise |=> !dq_drive);

  // R4
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_rise && cas_n) || (cas_rise && ras_n)) |=> !dq_drive);

  // R7
  cbr_exits_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !tm_q);

  // R8
  wcbr_enters_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n) |=> tm_q);

  // R11
  init_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |=> init_err);

  // R12
  ret_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |=> ret_err);

endmodule

bind dram_edo_model dram_edo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
  .cas_rise(cas_rise), .oe_rise(oe_rise), .tm_q(tm_q),
  .dq_drive(dq_drive), .init_err(init_err), .ret_err(ret_err)
);

// File: tb/tb_dram_edo_model.sv
module tb_dram_edo_model;

  localparam int ROWS = 16;
  localparam int COLS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out;
  logic       dq_drive, init_err, ret_err;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  logic [3:0] m [ROWS*COLS];
  bit         tm = 1'b0;

  always #10 clk = ~clk;

  dram_edo_model dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_drive(dq_drive), .init_err(init_err), .ret_err(ret_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_rd(input int r, input int c);
    int c0 = c & ~1;
    if (tm) return m[r*COLS + c0] ^ m[r*COLS + c0 + 1];
    return m[r*COLS + c];
  endfunction

  function automatic void model_wr(input int r, input int c, input logic [3:0] d);
    if (tm) begin
      m[r*COLS + (c & ~1)] = d;
      m[r*COLS + (c | 1)]  = d;
    end else m[r*COLS + c] = d;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    tm = 1'b0;
    repeat (3) tick();
    chk("R1 drive in reset", dq_drive, 0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic do_read(input int r, input int c);
    logic [3:0] e;
    e = exp_rd(r, c);
    addr = 4'(r); ras_n = 1'b0; tick();
    addr = 4'(c); cas_n = 1'b0; tick();
    chk("R2 read drive", dq_drive, 1);
    chk(tm ? "R9 test read data" : "R2 read data", dq_out, e);
    cas_n = 1'b1; tick();
    chk("R2 hold after CAS rise", {dq_drive, dq_out}, {1'b1, e});
    ras_n = 1'b1; tick();
    chk("R4 release at RAS rise", dq_drive, 0);
  endtask

  task automatic do_write(input int r, input int c, input logic [3:0] d);
    addr = 4'(r); ras_n = 1'b0; tick();
    addr = 4'(c); we_n = 1'b0; dq_in = d; cas_n = 1'b0; tick();
    chk("R3 early write no drive", dq_drive, 0);
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; tick();
    model_wr(r, c, d);
  endtask

  task automatic do_rmw(input int r, input int c, input logic [3:0] d);
    logic [3:0] e;
    e = exp_rd(r, c);
    addr = 4'(r); ras_n = 1'b0; tick();
    addr = 4'(c); cas_n = 1'b0; tick();
    chk("R5 rmw read data", dq_out, e);
    we_n = 1'b0; dq_in = d; tick();
    chk("R5 rmw keeps old data", {dq_drive, dq_out}, {1'b1, e});
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; tick();
    chk("R4 rmw release", dq_drive, 0);
    model_wr(r, c, d);
  endtask

  task automatic do_page(input int r, input int c1, input int c2);
    logic [3:0] e1, e2;
    e1 = exp_rd(r, c1); e2 = exp_rd(r, c2);
    addr = 4'(r); ras_n = 1'b0; tick();
    addr = 4'(c1); cas_n = 1'b0; tick();
    chk("R2 page first word", dq_out, e1);
    cas_n = 1'b1; tick();
    chk("R2 page hold", {dq_drive, dq_out}, {1'b1, e1});
    addr = 4'(c2); cas_n = 1'b0; tick();
    chk("R2 page second word", {dq_drive, dq_out}, {1'b1, e2});
    cas_n = 1'b1; ras_n = 1'b1; tick();
    chk("R4 page release", dq_drive, 0);
  endtask

  task automatic do_oe_rel(input int r, input int c);
    addr = 4'(r); ras_n = 1'b0; tick();
    addr = 4'(c); cas_n = 1'b0; tick();
    chk("R2 drive before OE rise", dq_drive, 1);
    oe_n = 1'b1; tick();
    chk("R4 OE rise release", dq_drive, 0);
    oe_n = 1'b0; tick();
    chk("R4 OE fall no redrive", dq_drive, 0);
    cas_n = 1'b1; ras_n = 1'b1; tick();
  endtask

  task automatic do_we_rel(input int r, input int c);
    addr = 4'(r); ras_n = 1'b0; tick();
    addr = 4'(c); cas_n = 1'b0; tick();
    cas_n = 1'b1; tick();
    chk("R2 drive with CAS high", dq_drive, 1);
    we_n = 1'b0; dq_in = 4'hF; tick();
    chk("R4 WE fall release", dq_drive, 0);
    we_n = 1'b1; ras_n = 1'b1; tick();
  endtask

  task automatic do_cbr();
    cas_n = 1'b0; tick();
    ras_n = 1'b0; tick();
    ras_n = 1'b1; cas_n = 1'b1; tick();
    tm = 1'b0;
  endtask

  task automatic do_wcbr();
    cas_n = 1'b0; we_n = 1'b0; tick();
    ras_n = 1'b0; tick();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick();
    tm = 1'b1;
  endtask

  task automatic do_ras_only(input int r);
    addr = 4'(r); ras_n = 1'b0; tick();
    ras_n = 1'b1; tick();
    tm = 1'b0;
  endtask

  task automatic refresh_all();
    for (int i = 0; i < ROWS; i++) do_cbr();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int op, r, c;
    void'($urandom(32'd4403));
    tick();
    chk("R1 reset drive", dq_drive, 0);
    chk("R1 reset errors", {init_err, ret_err}, 0);
    rst_n = 1'b1;
    repeat (20) tick();
    for (int i = 0; i < 4; i++) do_cbr();
    for (int i = 0; i < 4; i++) do_ras_only(i + 8);
    chk("R1 drive after init", dq_drive, 0);

    // fill memory, refreshing periodically
    for (int rr = 0; rr < ROWS; rr++) begin
      for (int cc = 0; cc < COLS; cc++) do_write(rr, cc, 4'($urandom));
      if (rr % 4 == 3) refresh_all();
    end
    chk("R11 no error after full init", init_err, 0);

    // directed: R6 row from address pins, R9 test mode
    do_write(3, 2, 4'hA);
    do_write(3, 3, 4'hA);
    do_read(3, 3);
    do_wcbr();
    do_read(3, 2);
    chk("R9 agree gives zero", dq_out, 4'h0);
    do_wcbr();
    do_read(3, 3);
    chk("R8 repeated entry keeps test mode", dq_out, 4'h0);
    do_cbr();
    do_write(3, 3, 4'h5);
    do_read(3, 3);
    chk("R7 counter refresh ends test mode", dq_out, 4'h5);
    do_wcbr();
    do_read(3, 2);
    chk("R9 disagree bits high", dq_out, 4'hF);
    do_write(3, 2, 4'h6);
    do_ras_only(3);
    do_read(3, 3);
    chk("R10 row-only ends test mode and R9 pair write", dq_out, 4'h6);
    do_rmw(5, 7, 4'h9);
    do_read(5, 7);
    chk("R5 rmw stored", dq_out, 4'h9);
    do_we_rel(6, 1);
    do_read(6, 1);
    refresh_all();

    // constrained random
    for (int i = 0; i < 400; i++) begin
      op = $urandom_range(0, 7);
      r  = $urandom_range(0, ROWS - 1);
      c  = $urandom_range(0, COLS - 1);
      case (op)
        0: do_read(r, c);
        1: do_write(r, c, 4'($urandom));
        2: do_rmw(r, c, 4'($urandom));
        3: do_page(r, c, $urandom_range(0, COLS - 1));
        4: do_oe_rel(r, c);
        5: do_we_rel(r, c);
        6: do_wcbr();
        default: if (c[0]) do_cbr(); else do_ras_only(r);
      endcase
      if (i % 30 == 29) refresh_all();
    end
    refresh_all();
    chk("R12 no retention error while refreshed", ret_err, 0);

    // counter refresh alone must cover all rows
    for (int k = 0; k < 4; k++) begin
      refresh_all();
      repeat (900) tick();
    end
    chk("R7 counter covers every row", ret_err, 0);
    repeat (3100) tick();
    chk("R12 retention error after window", ret_err, 1);
    tick();
    chk("R12 retention error sticky", ret_err, 1);

    // init boundary: seven refresh cycles are not enough
    do_reset();
    chk("R1 errors cleared", {init_err, ret_err}, 0);
    repeat (20) tick();
    for (int i = 0; i < 7; i++) do_cbr();
    addr = 4'd0; ras_n = 1'b0; tick();
    cas_n = 1'b0; tick();
    chk("R11 early access flagged", init_err, 1);
    cas_n = 1'b1; ras_n = 1'b1; tick();
    chk("R11 flag sticky", init_err, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule